// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is an SMBus target that gives a controller access to a bank of 8-bit configuration registers. It watches SCL and SDA through a synchronizer, recognises START, repeated START and STOP, and pulls SDA low through an output-enable to acknowledge bytes or to send read data. On the chip side it offers a plain register-file port: an index, a write byte with a one-cycle strobe, and a read byte returned in the same cycle.

A write transaction carries its 7-bit target address with the direction bit clear (D2h on the wire). It is followed by a starting index, a byte count and that many data bytes. The data lands at the starting index and then at each following index. A read transaction first sets the index with a short write and then issues a repeated START with the direction bit set (D3h). The target answers with a fixed count byte and then the register contents from the index onward. Single-byte access uses the same two forms: a write with a count of one, or a read that the controller ends after the first data byte.

Top module: `smb_idx_target`

## Requirements
- R1: The target ACKs the address bytes D2h and D3h. Any other address byte gets no ACK, and every later byte stays unacknowledged and causes no write until the next START, even if that byte is D2h.
- R2: In a write transaction the target ACKs the index byte, the count byte N (when N is nonzero) and N data bytes. Data byte k goes to index (start + k) modulo 256, one strobe per byte.
- R3: A count byte of 00h is not acknowledged, and no write strobe follows.
- R4: A data byte that arrives after N bytes have been written is not acknowledged and is not written.
- R5: After a repeated START with D3h, the first byte transmitted is the count 08h. The bytes after it are the register values starting at the index set by the preceding write phase, with the index advancing by one after each byte.
- R6: When the controller does not acknowledge a transmitted byte, the target releases SDA and transmits nothing further. After STOP it is idle and serves the next transaction normally.
- R7: A STOP before N data bytes keeps the bytes already written and writes nothing more.
- R8: A write to an index at or above the implemented register count is acknowledged but produces no write strobe. A read from such an index returns 00h.
- R9: The target changes its SDA drive only while SCL is low.
- R10: During and right after reset, SDA is released and the write strobe is low.
- R11: The index wraps from FFh to 00h within a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe | output | 1 | High to pull SDA low (open drain) |
| reg_addr | output | 8 | Register index for read and write |
| reg_wdata | output | 8 | Byte to write at reg_addr |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register value at reg_addr, valid in the same cycle |

## Verification
The assertions assume the controller keeps SCL low for longer than the synchronizer and edge-detector latency (three clock cycles). This lets every drive change the target makes settle before the next rising SCL edge. They also assume that SDA moves only in the middle of an SCL low phase, except for START and STOP. The bench controller model works in quarter-bit steps of four clock cycles and always changes SDA one full quarter away from an SCL edge. It also gives every transmitted byte its ACK or NACK before a STOP, so the SDA-drive and STOP-to-idle properties see only legal bus sequences.

// File: rtl/smb_idx_pkg.sv
`timescale 1ns/1ps
package smb_idx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WOFS,
    ST_WCNT,
    ST_WDATA,
    ST_RCNT,
    ST_RDATA,
    ST_IGNORE
  } txn_state_e;

  // address byte carries the 7-bit target address in its upper bits
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // acknowledge decision for a byte the target has just received
  function automatic logic rx_ack(input txn_state_e st, input logic [7:0] b,
                                  input logic [7:0] remain, input logic [6:0] dev);
    case (st)
      ST_ADDR:  return addr_hit(b, dev);
      ST_WOFS:  return 1'b1;
      ST_WCNT:  return b != 8'd0;
      ST_WDATA: return remain != 8'd0;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] idx_next(input logic [7:0] i);
    return i + 8'd1;
  endfunction

  function automatic logic idx_in_range(input logic [7:0] i, input int n);
    return 32'(i) < n;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  // idle bus is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      for (int k = STAGES - 1; k > 0; k--) begin
        scl_ff[k] <= scl_ff[k-1];
        sda_ff[k] <= sda_ff[k-1];
      end
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      scl_q     <= scl_ff[STAGES-1];
      sda_q     <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // SDA edges while SCL stays high mark bus conditions
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_txn_ctrl.sv
`timescale 1ns/1ps
module smb_txn_ctrl
  import smb_idx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] RD_COUNT = 8'd8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_byte,
  output logic       sda_drive,
  output logic [7:0] idx,
  output logic       wr_fire,
  output logic [7:0] wr_byte
);

  txn_state_e st;
  logic [3:0] bcnt;     // 0..7 data bits, 8 = ack slot low, 9 = ack slot high
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic [7:0] remain;
  logic       acked;
  logic       mack;
  logic       is_tx;
  logic       ack_now;

  assign is_tx   = (st == ST_RCNT) || (st == ST_RDATA);
  assign ack_now = rx_ack(st, rx_sh, remain, DEV_ADDR);
  assign wr_fire = scl_fall && (bcnt == 4'd8) && (st == ST_WDATA) && (remain != 8'd0);
  assign wr_byte = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bcnt      <= 4'd0;
      rx_sh     <= 8'd0;
      tx_sh     <= 8'd0;
      remain    <= 8'd0;
      idx       <= 8'd0;
      acked     <= 1'b0;
      mack      <= 1'b0;
      sda_drive <= 1'b0;
    end else if (start_ev) begin
      st        <= ST_ADDR;
      bcnt      <= 4'd0;
      sda_drive <= 1'b0;
    end else if (stop_ev) begin
      st        <= ST_IDLE;
      bcnt      <= 4'd0;
      sda_drive <= 1'b0;
    end else if (st != ST_IDLE && st != ST_IGNORE) begin
      if (scl_rise) begin
        if (bcnt < 4'd8) begin
          if (!is_tx) rx_sh <= {rx_sh[6:0], sda_s};
          bcnt <= bcnt + 4'd1;
        end else if (bcnt == 4'd8) begin
          mack <= ~sda_s;
          bcnt <= 4'd9;
        end
      end
      if (scl_fall) begin
        if (bcnt == 4'd8) begin
          // byte done: enter the acknowledge slot
          if (is_tx) begin
            sda_drive <= 1'b0;
            if (st == ST_RDATA) idx <= idx_next(idx);
          end else begin
            sda_drive <= ack_now;
            acked     <= ack_now;
            case (st)
              ST_WOFS:  idx    <= rx_sh;
              ST_WCNT:  remain <= rx_sh;
              ST_WDATA: if (remain != 8'd0) begin
                idx    <= idx_next(idx);
                remain <= remain - 8'd1;
              end
              default: ;
            endcase
          end
        end else if (bcnt == 4'd9) begin
          // acknowledge slot over: pick the next phase
          bcnt <= 4'd0;
          if (is_tx) begin
            if (mack) begin
              st        <= ST_RDATA;
              tx_sh     <= rd_byte;
              sda_drive <= ~rd_byte[7];
            end else begin
              st        <= ST_IGNORE;
              sda_drive <= 1'b0;
            end
          end else if (!acked) begin
            st        <= ST_IGNORE;
            sda_drive <= 1'b0;
          end else begin
            sda_drive <= 1'b0;
            case (st)
              ST_ADDR: if (rx_sh[0]) begin
                st        <= ST_RCNT;
                tx_sh     <= RD_COUNT;
                sda_drive <= ~RD_COUNT[7];
              end else begin
                st <= ST_WOFS;
              end
              ST_WOFS: st <= ST_WCNT;
              ST_WCNT: st <= ST_WDATA;
              default: ;
            endcase
          end
        end else if (is_tx && bcnt != 4'd0) begin
          tx_sh     <= {tx_sh[6:0], 1'b0};
          sda_drive <= ~tx_sh[6];
        end
      end
    end
  end

  // R1: once ignoring, the target never pulls SDA
  a_r1_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_drive);

  // R2: the index steps by one after every written byte
  a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (idx == $past(idx) + 8'd1));

  // R6: STOP leaves the target idle with SDA released
  a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == ST_IDLE) && !sda_drive);

  // R9: SDA drive moves only while the synchronized SCL is low
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive) |-> !scl_s);

endmodule

// File: rtl/smb_idx_target.sv
`timescale 1ns/1ps
module smb_idx_target
  import smb_idx_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] RD_COUNT    = 8'd8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);

  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       sda_drive, wr_fire, in_range;
  logic [7:0] idx, wr_byte, rd_masked;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smb_txn_ctrl #(.DEV_ADDR(DEV_ADDR), .RD_COUNT(RD_COUNT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .rd_byte   (rd_masked),
    .sda_drive (sda_drive),
    .idx       (idx),
    .wr_fire   (wr_fire),
    .wr_byte   (wr_byte)
  );

  // range gate: writes outside the bank vanish, reads there give zero (R8)
  assign in_range  = idx_in_range(idx, NUM_REGS);
  assign rd_masked = in_range ? reg_rdata : 8'h00;
  assign reg_we    = wr_fire && in_range;
  assign reg_addr  = idx;
  assign reg_wdata = wr_byte;
  assign sda_oe    = sda_drive;

endmodule

// File: tb/tb_smb_idx_target.sv
`timescale 1ns/1ps
module tb_smb_idx_target;

  localparam int NREG = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  int viol   = 0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;

  logic [7:0] rf   [NREG];
  logic [7:0] expv [NREG];
  logic [7:0] wbuf [8];

  always #2.5 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = (32'(reg_addr) < NREG) ? rf[reg_addr[3:0]] : 8'hEE;

  smb_idx_target dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  // environment register bank
  always @(posedge clk) begin
    if (rst_n && reg_we) begin
      we_cnt++;
      if (32'(reg_addr) < NREG) rf[reg_addr[3:0]] <= reg_wdata;
    end
  end

  // R9 monitor: drive may not change while SCL is high
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) viol++;
    prev_oe = sda_oe;
  end

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    return (32'(a) < NREG) ? expv[a[3:0]] : 8'h00;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_m = 1'b1; wq();
      b[i] = sda_line; wq();
      scl_m = 1'b0;
    end
    wq();
    sda_m = ~give_ack; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] off, input logic [7:0] cnt,
                          input int nsend, input string req);
    logic a;
    int   we0, nw;
    logic [7:0] ad;
    we0 = we_cnt; nw = 0;
    bus_start();
    send_byte(8'hD2, a); chk({req, " R1 write addr ack"}, a, 1);
    send_byte(off, a);   chk({req, " R2 index ack"}, a, 1);
    send_byte(cnt, a);   chk({req, " R3 count ack"}, a, int'(cnt != 8'd0));
    if (a) begin
      for (int k = 0; k < nsend; k++) begin
        send_byte(wbuf[k], a);
        chk({req, " R4 data ack"}, a, int'(k < int'(cnt)));
        if (!a) break;
        ad = off + 8'(k);
        if (32'(ad) < NREG) begin
          expv[ad[3:0]] = wbuf[k];
          nw++;
        end
      end
    end
    bus_stop(); wq();
    chk({req, " R2 strobe count"}, we_cnt - we0, nw);
  endtask

  task automatic do_read(input logic [7:0] off, input int n, input string req);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, a); chk({req, " R1 addr ack"}, a, 1);
    send_byte(off, a);   chk({req, " R5 index ack"}, a, 1);
    bus_start();
    send_byte(8'hD3, a); chk({req, " R1 read addr ack"}, a, 1);
    recv_byte(1'b1, b);  chk({req, " R5 count byte"}, b, 8'h08);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk({req, " R5 data"}, b, model_rd(off + 8'(k)));
    end
    bus_stop(); wq();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    int   we0;
    int   seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < NREG; i++) begin
      rf[i]   = 8'(i * 17) ^ 8'h5A;
      expv[i] = 8'(i * 17) ^ 8'h5A;
    end
    repeat (3) @(posedge clk); #1;
    chk("R10 oe in reset", sda_oe, 0);
    chk("R10 we in reset", reg_we, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R10 oe after reset", sda_oe, 0);
    chk("R10 we after reset", reg_we, 0);

    // R2 directed block write, then R5 read-back
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(8'd3, 8'd4, 4, "R2 block");
    do_read(8'd3, 4, "R5 block");

    // R1 foreign address ignored, even a later D2h byte
    we0 = we_cnt;
    bus_start();
    send_byte(8'hA4, a); chk("R1 foreign addr nack", a, 0);
    send_byte(8'hD2, a); chk("R1 D2 ignored after nack", a, 0);
    send_byte(8'h05, a); chk("R1 later byte ignored", a, 0);
    bus_stop(); wq();
    chk("R1 no strobe", we_cnt - we0, 0);

    // R3 zero count
    do_write(8'd6, 8'd0, 1, "R3 zero");
    // R4 extra byte beyond count
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    do_write(8'd8, 8'd2, 3, "R4 extra");
    do_read(8'd8, 3, "R4 readback");
    // R7 early stop
    wbuf[0] = 8'hC7; wbuf[1] = 8'hC8;
    do_write(8'd12, 8'd5, 2, "R7 early");
    do_read(8'd12, 3, "R7 readback");
    // R8 out of range write and read
    wbuf[0] = 8'h99;
    do_write(8'h20, 8'd1, 1, "R8 oor");
    do_read(8'h20, 1, "R8 oor read");
    // R11 wrap from FFh to 00h
    wbuf[0] = 8'h3C; wbuf[1] = 8'h4D;
    do_write(8'hFF, 8'd2, 2, "R11 wrap");
    do_read(8'hFF, 2, "R11 wrap read");
    // R6 single-byte read ended by NACK, then a normal transaction
    do_read(8'd0, 1, "R6 single");
    wbuf[0] = 8'h77;
    do_write(8'd1, 8'd1, 1, "R6 next");
    do_read(8'd1, 1, "R6 next read");

    // constrained random traffic
    for (int it = 0; it < 12; it++) begin
      logic [7:0] off;
      int cnt;
      off = 8'($urandom_range(0, 19));
      cnt = $urandom_range(1, 6);
      for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
      do_write(off, 8'(cnt), cnt, "R2 random");
      do_read(off, cnt, "R5 random");
    end

    chk("R9 drive changed with SCL high", viol, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule